// File: doc/BRIEF.md
# Four-Master Three-Slave Bus Switch

This block joins four bus masters to three bus slaves. Every master port carries a 32-bit address, 32-bit write and read data, a write strobe and a valid/ready handshake. The top bits of the address choose the target slave. Masters that aim at different slaves reach them in the same cycle. When two or more masters aim at one slave, that slave port picks a winner by a fixed order of master indices. Any master can raise a boost input to jump ahead of that order for as long as it holds the input high.

A transfer is one valid/ready handshake. After a slave port has granted a master, it stays with that master until the slave returns ready. It only arbitrates again once that single transfer is done. An address that falls outside every region completes at once with an error flag, and no slave sees it. The asynchronous active-low reset is synchronised inside the block before it releases the internal state.

Top module: `xbar_switch`

## Requirements
- R1: Address bits [31:28] select the slave: 4'h0 selects slave 0, 4'h4 selects slave 1 and 4'h8 selects slave 2. The request appears only at that slave's port.
- R2: A valid request whose bits [31:28] match no region raises m_err and m_ready for that master in the same cycle. No slave port asserts s_valid for it.
- R3: With no boost active among the contenders, the lowest-numbered requesting master wins a slave port (master 0 is first, master 3 is last).
- R4: A contender with m_boost high wins over every contender without boost.
- R5: Among boosted contenders, the lowest-numbered one wins.
- R6: If a slave port presents a request while s_ready is low, the same master keeps the port and the same address in following cycles until s_ready is seen high. This holds even when a higher-priority or boosted master arrives.
- R7: Masters that target different slaves are all granted in the same cycle.
- R8: A master that is not granted, or that has no valid request, sees m_ready low.
- R9: The granted master's address, write strobe and write data appear on the slave port. The slave's s_rdata returns on that master's m_rdata.
- R10: After reset, with no master valid, every s_valid and m_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 4 | Request valid, one bit per master |
| m_write | input | 4 | 1 = write, 0 = read, per master |
| m_boost | input | 4 | Temporary priority raise, per master |
| m_addr | input | 4x32 | Master addresses |
| m_wdata | input | 4x32 | Master write data |
| m_ready | output | 4 | Transfer done this cycle, per master |
| m_err | output | 4 | Unmapped address flag, per master |
| m_rdata | output | 4x32 | Read data back to each master |
| s_valid | output | 3 | Request valid at each slave |
| s_write | output | 3 | Write strobe at each slave |
| s_addr | output | 3x32 | Address at each slave |
| s_wdata | output | 3x32 | Write data at each slave |
| s_ready | input | 3 | Slave accepts the transfer |
| s_rdata | input | 3x32 | Read data from each slave |

## Verification
The bench keeps a slave stalled while a stronger or boosted master turns up, to prove the grant holds. A switch that re-arbitrates every cycle would swap the address under a stalled slave. It sets boost on several masters at once: an arbiter that ignores the boost, or breaks ties among boosted masters in the wrong order, picks the wrong master. It sends unmapped addresses in the same cycle as mapped traffic. A faulty decoder would either leak such a request to a slave or leave the master hanging without ready. It also sends simultaneous requests to distinct slaves, where any coupling between the ports would show up as a lost ready.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_NUM_M         = 4;
  localparam int XB_NUM_S         = 3;
  localparam int XB_AW            = 32;
  localparam int XB_DW            = 32;
  localparam int XB_SEL_W         = 4;
  localparam int XB_REGION_STRIDE = 4;
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int NUM_S         = 3,
  parameter int SEL_W         = 4,
  parameter int REGION_STRIDE = 4
) (
  input  logic [SEL_W-1:0] tag,
  output logic [NUM_S-1:0] hit,
  output logic             miss
);
  always_comb begin
    for (int j = 0; j < NUM_S; j++) begin
      hit[j] = (tag == SEL_W'(j * REGION_STRIDE));
    end
    miss = ~|hit;
  end
endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int NUM_M = 4
) (
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] boost,
  output logic [NUM_M-1:0] pick
);
  logic [NUM_M-1:0] boosted;
  logic [NUM_M-1:0] pool;

  always_comb begin
    boosted = req & boost;
    pool    = (|boosted) ? boosted : req;
    pick    = '0;
    for (int i = NUM_M - 1; i >= 0; i--) begin
      if (pool[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_slave_port.sv
module xbar_slave_port #(
  parameter int NUM_M = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_M-1:0]          req,
  input  logic [NUM_M-1:0]          boost,
  input  logic [NUM_M-1:0]          m_write,
  input  logic [NUM_M-1:0][AW-1:0]  m_addr,
  input  logic [NUM_M-1:0][DW-1:0]  m_wdata,
  input  logic                      s_ready,
  output logic [NUM_M-1:0]          gnt,
  output logic                      s_valid,
  output logic                      s_write,
  output logic [AW-1:0]             s_addr,
  output logic [DW-1:0]             s_wdata
);
  logic [NUM_M-1:0] pick;
  logic [NUM_M-1:0] owner_q;
  logic             lock_q;
  logic             lock_d;
  logic             owner_en;

  xbar_arbiter #(.NUM_M(NUM_M)) u_arb (
    .req   (req),
    .boost (boost),
    .pick  (pick)
  );

  always_comb begin
    gnt     = lock_q ? owner_q : pick;
    s_valid = |gnt;
    s_write = 1'b0;
    s_addr  = '0;
    s_wdata = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (gnt[i]) begin
        s_write = s_write | m_write[i];
        s_addr  = s_addr  | m_addr[i];
        s_wdata = s_wdata | m_wdata[i];
      end
    end
  end

  always_comb begin
    owner_en = s_valid & ~s_ready;
    lock_d   = owner_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
    end else if (owner_en) begin
      owner_q <= gnt;
    end
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int NUM_M         = XB_NUM_M,
  parameter int NUM_S         = XB_NUM_S,
  parameter int AW            = XB_AW,
  parameter int DW            = XB_DW,
  parameter int SEL_W         = XB_SEL_W,
  parameter int REGION_STRIDE = XB_REGION_STRIDE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_M-1:0]         m_valid,
  input  logic [NUM_M-1:0]         m_write,
  input  logic [NUM_M-1:0]         m_boost,
  input  logic [NUM_M-1:0][AW-1:0] m_addr,
  input  logic [NUM_M-1:0][DW-1:0] m_wdata,
  output logic [NUM_M-1:0]         m_ready,
  output logic [NUM_M-1:0]         m_err,
  output logic [NUM_M-1:0][DW-1:0] m_rdata,
  output logic [NUM_S-1:0]         s_valid,
  output logic [NUM_S-1:0]         s_write,
  output logic [NUM_S-1:0][AW-1:0] s_addr,
  output logic [NUM_S-1:0][DW-1:0] s_wdata,
  input  logic [NUM_S-1:0]         s_ready,
  input  logic [NUM_S-1:0][DW-1:0] s_rdata
);
  localparam int TAG_LSB = AW - SEL_W;

  logic                         rst_sync_n;
  logic [NUM_M-1:0][NUM_S-1:0]  hit;
  logic [NUM_M-1:0]             miss;
  logic [NUM_S-1:0][NUM_M-1:0]  req_s;
  logic [NUM_S-1:0][NUM_M-1:0]  gnt;

  xbar_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  for (genvar gi = 0; gi < NUM_M; gi++) begin : g_dec
    xbar_decode #(
      .NUM_S         (NUM_S),
      .SEL_W         (SEL_W),
      .REGION_STRIDE (REGION_STRIDE)
    ) u_dec (
      .tag  (m_addr[gi][AW-1:TAG_LSB]),
      .hit  (hit[gi]),
      .miss (miss[gi])
    );
  end

  always_comb begin
    for (int j = 0; j < NUM_S; j++) begin
      for (int i = 0; i < NUM_M; i++) begin
        req_s[j][i] = m_valid[i] & hit[i][j];
      end
    end
  end

  for (genvar gj = 0; gj < NUM_S; gj++) begin : g_sp
    xbar_slave_port #(
      .NUM_M (NUM_M),
      .AW    (AW),
      .DW    (DW)
    ) u_port (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .req     (req_s[gj]),
      .boost   (m_boost),
      .m_write (m_write),
      .m_addr  (m_addr),
      .m_wdata (m_wdata),
      .s_ready (s_ready[gj]),
      .gnt     (gnt[gj]),
      .s_valid (s_valid[gj]),
      .s_write (s_write[gj]),
      .s_addr  (s_addr[gj]),
      .s_wdata (s_wdata[gj])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_M; i++) begin
      m_err[i]   = m_valid[i] & miss[i];
      m_ready[i] = m_err[i];
      m_rdata[i] = '0;
      for (int j = 0; j < NUM_S; j++) begin
        if (gnt[j][i]) begin
          m_ready[i] = m_ready[i] | s_ready[j];
          m_rdata[i] = m_rdata[i] | s_rdata[j];
        end
      end
    end
  end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int NUM_M = 4,
  parameter int NUM_S = 3,
  parameter int AW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_M-1:0]         m_valid,
  input logic [NUM_M-1:0]         m_ready,
  input logic [NUM_M-1:0]         m_err,
  input logic [NUM_S-1:0]         s_valid,
  input logic [NUM_S-1:0]         s_ready,
  input logic [NUM_S-1:0][AW-1:0] s_addr,
  input logic [NUM_S-1:0][NUM_M-1:0] gnt
);
  for (genvar gi = 0; gi < NUM_M; gi++) begin : g_m
    AST_ERR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[gi] |-> (m_ready[gi] && m_valid[gi])); // R2
    AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid[gi] |-> !m_ready[gi]); // R8
  end

  for (genvar gj = 0; gj < NUM_S; gj++) begin : g_s
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[gj])); // R3
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid[gj] && !s_ready[gj]) |=> (s_valid[gj] && $stable(s_addr[gj]))); // R6
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid == '0) |-> (s_valid == '0)); // R10
endmodule

bind xbar_switch xbar_checker #(
  .NUM_M (NUM_M),
  .NUM_S (NUM_S),
  .AW    (AW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_err   (m_err),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_addr  (s_addr),
  .gnt     (gnt)
);

// File: tb/sim_xbar_switch.sv
module sim_xbar_switch;
  logic clk;
  logic rst_n;
  logic [3:0]       m_valid, m_write, m_boost;
  logic [3:0][31:0] m_addr, m_wdata;
  logic [3:0]       m_ready, m_err;
  logic [3:0][31:0] m_rdata;
  logic [2:0]       s_valid, s_write;
  logic [2:0][31:0] s_addr, s_wdata;
  logic [2:0]       s_ready;
  logic [2:0][31:0] s_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  bit  lk [3];
  int  own [3];
  bit  pending [4];

  xbar_switch u0 (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_write(m_write), .m_boost(m_boost),
    .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata),
    .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int dec(logic [31:0] a);
    case (a[31:28])
      4'h0: return 0;
      4'h4: return 1;
      4'h8: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic int pick(int j);
    int first = -1;
    int firstb = -1;
    for (int i = 3; i >= 0; i--) begin
      if (m_valid[i] && dec(m_addr[i]) == j) begin
        first = i;
        if (m_boost[i]) firstb = i;
      end
    end
    return (firstb >= 0) ? firstb : first;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_check(string tag);
    int g [3];
    for (int j = 0; j < 3; j++) begin
      g[j] = lk[j] ? own[j] : pick(j);
      chk(s_valid[j] == (g[j] >= 0), {tag, " R1 R3 R4 R5 R6 R7 s_valid"}, 32'(s_valid[j]), 32'(g[j] >= 0));
      if (g[j] >= 0) begin
        chk(s_addr[j] == m_addr[g[j]], {tag, " R9 s_addr"}, s_addr[j], m_addr[g[j]]);
        chk(s_wdata[j] == m_wdata[g[j]], {tag, " R9 s_wdata"}, s_wdata[j], m_wdata[g[j]]);
        chk(s_write[j] == m_write[g[j]], {tag, " R9 s_write"}, 32'(s_write[j]), 32'(m_write[g[j]]));
      end
    end
    for (int i = 0; i < 4; i++) begin
      bit e_err;
      bit e_rdy;
      int d;
      d = dec(m_addr[i]);
      e_err = m_valid[i] && d < 0;
      e_rdy = e_err;
      for (int j = 0; j < 3; j++) if (g[j] == i && s_ready[j]) e_rdy = 1;
      chk(m_err[i] == e_err, {tag, " R2 m_err"}, 32'(m_err[i]), 32'(e_err));
      chk(m_ready[i] == e_rdy, {tag, " R2 R8 m_ready"}, 32'(m_ready[i]), 32'(e_rdy));
      if (e_rdy && !e_err)
        chk(m_rdata[i] == s_rdata[d], {tag, " R9 m_rdata"}, m_rdata[i], s_rdata[d]);
    end
    for (int j = 0; j < 3; j++) begin
      lk[j]  = (g[j] >= 0) && !s_ready[j];
      own[j] = g[j];
    end
  endtask

  task automatic cyc(string tag);
    #1;
    model_check(tag);
    for (int i = 0; i < 4; i++) pending[i] = m_valid[i] && !m_ready[i];
    @(negedge clk);
  endtask

  task automatic idle();
    m_valid = '0; m_boost = '0; s_ready = '1;
    cyc("idle");
  endtask

  task automatic put(int i, logic [31:0] a);
    m_valid[i] = 1'b1;
    m_addr[i]  = a;
    m_wdata[i] = a ^ 32'h5A5A_0000;
    m_write[i] = a[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; m_valid = '0; m_write = '0; m_boost = '0;
    m_addr = '0; m_wdata = '0; s_ready = '0;
    for (int j = 0; j < 3; j++) s_rdata[j] = 32'hC0DE_0000 + 32'(j);
    for (int j = 0; j < 3; j++) begin lk[j] = 0; own[j] = -1; end
    for (int i = 0; i < 4; i++) pending[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(s_valid == 3'b000, "R10 reset s_valid", 32'(s_valid), 32'h0);
    chk(m_ready == 4'b0000, "R10 reset m_ready", 32'(m_ready), 32'h0);
    @(negedge clk);

    // R1 and R9: master 1 reads from slave 1
    put(1, 32'h4000_0010); s_ready = '1;
    #1;
    chk(s_valid == 3'b010, "R1 decode", 32'(s_valid), 32'h2);
    chk(m_rdata[1] == s_rdata[1], "R9 rdata", m_rdata[1], s_rdata[1]);
    #0; cyc("R1");
    idle();

    // R2: unmapped
    put(2, 32'hF000_0000); put(0, 32'h0000_0004);
    #1;
    chk(m_err[2] && m_ready[2], "R2 err+ready", {30'd0, m_err[2], m_ready[2]}, 32'h3);
    chk(s_valid == 3'b001, "R2 no leak", 32'(s_valid), 32'h1);
    cyc("R2");
    idle();

    // R3: fixed order
    put(0, 32'h8000_0000); put(1, 32'h8000_0100); put(3, 32'h8000_0300);
    #1;
    chk(s_addr[2] == 32'h8000_0000, "R3 fixed order", s_addr[2], 32'h8000_0000);
    cyc("R3");
    idle();

    // R4: boost wins
    put(0, 32'h8000_0000); put(1, 32'h8000_0100); put(3, 32'h8000_0300);
    m_boost[3] = 1;
    #1;
    chk(s_addr[2] == 32'h8000_0300, "R4 boost wins", s_addr[2], 32'h8000_0300);
    cyc("R4");
    idle();

    // R5: boosted tie
    put(0, 32'h8000_0000); put(1, 32'h8000_0100); put(3, 32'h8000_0300);
    m_boost[1] = 1; m_boost[3] = 1;
    #1;
    chk(s_addr[2] == 32'h8000_0100, "R5 boosted tie", s_addr[2], 32'h8000_0100);
    cyc("R5");
    idle();

    // R6: stall holds grant
    put(3, 32'h0000_0300); s_ready = 3'b000;
    cyc("R6a");
    put(0, 32'h0000_0000); m_boost[0] = 1;
    #1;
    chk(s_addr[0] == 32'h0000_0300, "R6 hold under stall", s_addr[0], 32'h0000_0300);
    chk(m_ready[0] == 0, "R6 R8 loser waits", 32'(m_ready[0]), 32'h0);
    cyc("R6b");
    s_ready = 3'b001;
    #1;
    chk(m_ready[3] == 1, "R6 owner completes", 32'(m_ready[3]), 32'h1);
    cyc("R6c");
    m_valid[3] = 0;
    #1;
    chk(s_addr[0] == 32'h0000_0000, "R6 released", s_addr[0], 32'h0);
    cyc("R6d");
    idle();

    // R7: parallel
    put(0, 32'h0000_0000); put(1, 32'h4000_0000); put(2, 32'h8000_0000);
    #1;
    chk(m_ready == 4'b0111, "R7 parallel", 32'(m_ready), 32'h7);
    cyc("R7");
    idle();

    // R8: loser sees no ready
    put(0, 32'h4000_0000); put(1, 32'h4000_0040);
    #1;
    chk(m_ready[1] == 0, "R8 loser", 32'(m_ready[1]), 32'h0);
    cyc("R8");
    idle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 4; i++) begin
        if (!pending[i]) begin
          int r;
          r = $urandom % 6;
          m_valid[i] = ($urandom % 10) < 6;
          m_write[i] = $urandom % 2;
          m_wdata[i] = $urandom;
          m_addr[i]  = {4'h0, 28'($urandom)};
          case (r)
            1: m_addr[i][31:28] = 4'h4;
            2, 3: m_addr[i][31:28] = 4'h8;
            4: m_addr[i][31:28] = 4'hC;
            default: m_addr[i][31:28] = 4'h0;
          endcase
        end
        m_boost[i] = ($urandom % 4) == 0;
      end
      for (int j = 0; j < 3; j++) begin
        s_ready[j] = ($urandom % 2) == 1;
        s_rdata[j] = $urandom;
      end
      cyc("rand");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule